// File: doc/BRIEF.md
# Dual Configurable Decade Ripple Counter

The block holds two independent counting units. Each unit is split into a divide-by-two stage, which drives output bit 0, and a divide-by-five stage, which drives output bits 3 to 1. Each stage has its own count input, so a unit has two of them: `cp0` feeds the two-stage and `cp1` feeds the five-stage. A stage steps only when its count input goes from high to low. Each unit also has its own active-high asynchronous clear.

All count inputs are sampled on one system clock, and a falling edge is detected there. The link between the two stages of a unit runs on the same clock, so a chain of stages still ripples but stays synchronous. A two-bit mode per unit picks how the stages are linked:

- BCD decade: bit 0 feeds the five-stage.
- Bi-quinary decade: bit 3 feeds the two-stage, and bit 0 becomes a symmetric decade output.
- Split: both stages run from their own inputs.

Wiring the bit 3 output of one unit to a count input of the other unit gives division ratios up to 100.

Top module: `dual_decade_counter`

## Requirements
- R1: While `rst_n` is low, all eight outputs read 0.
- R2: In split mode (`mode` = 2'b10 or 2'b11), output bit 0 toggles once for each high-to-low change of `cp0`. The new value is visible after the first system clock edge at which `cp0` is sampled low.
- R3: In split mode, output bits 3..1 step through the values 0, 1, 2, 3, 4 and back to 0, one step for each high-to-low change of `cp1`. No output value ever exceeds 9 in any mode.
- R4: A rising change, or a level held for many clocks, on a count input never moves a stage.
- R5: In BCD mode (`mode` = 2'b00), `cp0` falls make bits 3..0 count 0 to 9 in binary and then wrap. Bits 3..1 step one system clock after bit 0 falls, and `cp1` has no effect.
- R6: In bi-quinary mode (`mode` = 2'b01), `cp1` falls step bits 3..1, and bit 0 toggles one system clock after bit 3 falls. After n falls of `cp1`, the output is {n mod 5, (n div 5) mod 2} with bits 3..1 first. In this mode `cp0` has no effect.
- R7: A high level on a unit's clear drives all four outputs of that unit to 0 at once, without waiting for a system clock edge.
- R8: A clear of one unit leaves the count of the other unit unchanged.
- R9: Count-input falls that arrive while clear is high are ignored. The output is still 0 just after release, and counting resumes at the first fall after release.
- R10: With unit A in BCD mode, unit A bit 3 feeding unit B `cp0`, and unit B in BCD mode, unit B holds the tens digit. Both units return to 0 together after 100 falls of unit A `cp0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all count inputs are sampled |
| rst_n | input | 1 | Active-low reset of the whole block |
| clr_a | input | 1 | Asynchronous clear of unit A, active high |
| cp0_a | input | 1 | Count input of the unit A divide-by-two stage |
| cp1_a | input | 1 | Count input of the unit A divide-by-five stage |
| mode_a | input | 2 | Stage linking of unit A: 00 BCD, 01 bi-quinary, 1x split |
| q_a | output | 4 | Unit A outputs; bit 0 from the two-stage, bits 3..1 from the five-stage |
| clr_b | input | 1 | Asynchronous clear of unit B, active high |
| cp0_b | input | 1 | Count input of the unit B divide-by-two stage |
| cp1_b | input | 1 | Count input of the unit B divide-by-five stage |
| mode_b | input | 2 | Stage linking of unit B, same encoding as `mode_a` |
| q_b | output | 4 | Unit B outputs, same layout as `q_a` |

## Verification
A clear and a stage step can land in the same system clock cycle. A count fall can reach a unit while its clear is high, and an internal link fall can still be travelling from one stage to the next. The bench provokes this by raising clear partway through a counting sequence and driving a full `cp0` pulse while clear is held. It then judges the result at the ports: the output is zero right after release, and the first fall after release yields exactly 1. In the cascade, each input fall can travel across three links to reach unit B, so the bench allows time for that path before it compares both digits.

// File: rtl/dcrc_pkg.sv
package dcrc_pkg;

    // How the two stages of one unit are linked together
    typedef enum logic [1:0] {
        CHAIN_BCD       = 2'b00,
        CHAIN_BIQUINARY = 2'b01,
        CHAIN_SPLIT     = 2'b10,
        CHAIN_SPLIT_ALT = 2'b11
    } chain_mode_e;

    localparam int LO_MOD    = 2;
    localparam int HI_MOD    = 5;
    localparam int UNIT_BITS = 4;

endpackage

// File: rtl/dcrc_fall_sampler.sv
module dcrc_fall_sampler #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig,
    output logic [WIDTH-1:0] fall
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // A fall is a high sample followed by a low input at this edge
    assign fall = s_q.prev & ~sig;

endmodule

// File: rtl/dcrc_divn_stage.sv
module dcrc_divn_stage #(
    parameter int MOD = 5
) (
    input  logic                clk,
    input  logic                arst,
    input  logic                adv,
    output logic [CW-1:0]       cnt,
    output logic                msb_fall
);

    localparam int CW = (MOD > 2) ? $clog2(MOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(MOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          msb_prev;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.msb_prev = s_q.cnt[CW-1];
        if (adv) begin
            if (s_q.cnt == LAST) s_d.cnt = '0;
            else                 s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) s_q <= '0;
        else      s_q <= s_d;
    end

    assign cnt      = s_q.cnt;
    // Falling top bit, seen one system clock after it happened
    assign msb_fall = s_q.msb_prev & ~s_q.cnt[CW-1];

endmodule

// File: rtl/dcrc_unit.sv
module dcrc_unit
    import dcrc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 cp0,
    input  logic                 cp1,
    input  logic [1:0]           mode,
    output logic [UNIT_BITS-1:0] q
);

    localparam int LO_W = (LO_MOD > 2) ? $clog2(LO_MOD) : 1;
    localparam int HI_W = (HI_MOD > 2) ? $clog2(HI_MOD) : 1;

    chain_mode_e chain;
    logic [1:0]  ext_fall;
    logic        arst;
    logic        adv_lo, adv_hi;
    logic        lo_fall, hi_fall;
    logic [LO_W-1:0] lo_cnt;
    logic [HI_W-1:0] hi_cnt;

    assign chain = chain_mode_e'(mode);
    assign arst  = clr | ~rst_n;

    dcrc_fall_sampler #(.WIDTH(2)) i_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({cp1, cp0}),
        .fall  (ext_fall)
    );

    always_comb begin
        unique case (chain)
            CHAIN_BCD: begin
                adv_lo = ext_fall[0];
                adv_hi = lo_fall;
            end
            CHAIN_BIQUINARY: begin
                adv_lo = hi_fall;
                adv_hi = ext_fall[1];
            end
            default: begin
                adv_lo = ext_fall[0];
                adv_hi = ext_fall[1];
            end
        endcase
    end

    dcrc_divn_stage #(.MOD(LO_MOD)) i_lo (
        .clk      (clk),
        .arst     (arst),
        .adv      (adv_lo),
        .cnt      (lo_cnt),
        .msb_fall (lo_fall)
    );

    dcrc_divn_stage #(.MOD(HI_MOD)) i_hi (
        .clk      (clk),
        .arst     (arst),
        .adv      (adv_hi),
        .cnt      (hi_cnt),
        .msb_fall (hi_fall)
    );

    assign q = {hi_cnt, lo_cnt};

endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
    import dcrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_a,
    input  logic       cp0_a,
    input  logic       cp1_a,
    input  logic [1:0] mode_a,
    output logic [3:0] q_a,
    input  logic       clr_b,
    input  logic       cp0_b,
    input  logic       cp1_b,
    input  logic [1:0] mode_b,
    output logic [3:0] q_b
);

    localparam int NUM_UNITS = 2;

    logic [NUM_UNITS-1:0]                clr_v, cp0_v, cp1_v;
    logic [NUM_UNITS-1:0][1:0]           mode_v;
    logic [NUM_UNITS-1:0][UNIT_BITS-1:0] q_v;

    assign clr_v  = {clr_b, clr_a};
    assign cp0_v  = {cp0_b, cp0_a};
    assign cp1_v  = {cp1_b, cp1_a};
    assign mode_v = {mode_b, mode_a};

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        dcrc_unit i_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_v[u]),
            .cp0   (cp0_v[u]),
            .cp1   (cp1_v[u]),
            .mode  (mode_v[u]),
            .q     (q_v[u])
        );
    end

    assign q_a = q_v[0];
    assign q_b = q_v[1];

endmodule

// File: rtl/dual_decade_counter_chk.sv
module dual_decade_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_a,
    input logic       cp0_a,
    input logic [1:0] mode_a,
    input logic [3:0] q_a,
    input logic       clr_b,
    input logic [3:0] q_b
);

    assert_range_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_a <= 4'd9);

    assert_range_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_b <= 4'd9);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a || clr_b) |-> ((!clr_a || q_a == 4'd0) && (!clr_b || q_b == 4'd0)));

    assert_release_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_a) |-> (q_a == 4'd0));

    // Bit 0 holds when cp0 had no fall and bi-quinary linking is not active
    assert_hold_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a != 2'b01 && !clr_a && !($past(cp0_a) && !cp0_a))
        |=> (clr_a || $stable(q_a[0])));

    assert_biq_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 2'b01 && !clr_a && $fell(q_a[3]))
        |=> (clr_a || q_a[0] != $past(q_a[0])));

endmodule

bind dual_decade_counter dual_decade_counter_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_a  (clr_a),
    .cp0_a  (cp0_a),
    .mode_a (mode_a),
    .q_a    (q_a),
    .clr_b  (clr_b),
    .q_b    (q_b)
);

// File: tb/test_dual_decade_counter.sv
`timescale 1ns/1ps
module test_dual_decade_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_a = 1'b0, cp0_a = 1'b0, cp1_a = 1'b0;
    logic       clr_b = 1'b0, cp0_b_drv = 1'b0, cp1_b = 1'b0;
    logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
    logic       casc = 1'b0;
    logic       cp0_b;
    logic [3:0] q_a, q_b;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    assign cp0_b = casc ? q_a[3] : cp0_b_drv;

    always #10 clk = ~clk;

    dual_decade_counter i_dual_decade_counter (
        .clk(clk), .rst_n(rst_n),
        .clr_a(clr_a), .cp0_a(cp0_a), .cp1_a(cp1_a), .mode_a(mode_a), .q_a(q_a),
        .clr_b(clr_b), .cp0_b(cp0_b), .cp1_b(cp1_b), .mode_b(mode_b), .q_b(q_b)
    );

    // {mode[1:0], sel (0 = cp0, 1 = cp1), pulses[6:0], expected q[3:0]}
    localparam int NVEC = 16;
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 7'd1,  4'd1},
        {2'b00, 1'b0, 7'd5,  4'd5},
        {2'b00, 1'b0, 7'd9,  4'd9},
        {2'b00, 1'b0, 7'd10, 4'd0},
        {2'b00, 1'b0, 7'd13, 4'd3},
        {2'b00, 1'b1, 7'd4,  4'd0},
        {2'b01, 1'b1, 7'd1,  4'b0010},
        {2'b01, 1'b1, 7'd4,  4'b1000},
        {2'b01, 1'b1, 7'd5,  4'b0001},
        {2'b01, 1'b1, 7'd7,  4'b0101},
        {2'b01, 1'b1, 7'd10, 4'b0000},
        {2'b01, 1'b0, 7'd3,  4'b0000},
        {2'b10, 1'b0, 7'd3,  4'b0001},
        {2'b10, 1'b1, 7'd3,  4'b0110},
        {2'b11, 1'b1, 7'd5,  4'b0000},
        {2'b11, 1'b0, 7'd2,  4'b0000}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_cp(input int unit, input int sel, input logic v);
        if (unit == 0) begin
            if (sel == 0) cp0_a = v; else cp1_a = v;
        end else begin
            if (sel == 0) cp0_b_drv = v; else cp1_b = v;
        end
    endtask

    // One full high-low pulse, then time for the ripple to settle
    task automatic pulse(input int unit, input int sel);
        set_cp(unit, sel, 1'b1);
        repeat (2) @(negedge clk);
        set_cp(unit, sel, 1'b0);
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_a();
        clr_a = 1'b1;
        repeat (2) @(negedge clk);
        clr_a = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset unit A", q_a, 4'd0);
        check("R1 reset unit B", q_b, 4'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk on unit A
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            clear_a();
            mode_a = VEC[i][13:12];
            repeat (2) @(negedge clk);
            for (int p = 0; p < int'(VEC[i][10:4]); p++) pulse(0, int'(VEC[i][11]));
            case (VEC[i][13:12])
                2'b00:   tag = "R5 table";
                2'b01:   tag = "R6 table";
                default: tag = VEC[i][11] ? "R3 table" : "R2 table";
            endcase
            check(tag, q_a, VEC[i][3:0]);
        end

        // R5: every BCD state in order
        clear_a();
        mode_a = 2'b00;
        for (int n = 1; n <= 10; n++) begin
            pulse(0, 0);
            check("R5 BCD sequence", q_a, 4'(n % 10));
        end

        // R6: bi-quinary sequence, decade output on bit 0
        clear_a();
        mode_a = 2'b01;
        for (int n = 1; n <= 10; n++) begin
            pulse(0, 1);
            check("R6 bi-quinary sequence", q_a, {3'(n % 5), 1'((n / 5) % 2)});
        end

        // R4: rising change and long levels do nothing
        clear_a();
        mode_a = 2'b10;
        cp0_a = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 rise ignored", q_a, 4'd0);
        cp0_a = 1'b0;
        repeat (8) @(negedge clk);
        check("R4 fall counts", q_a, 4'd1);
        repeat (8) @(negedge clk);
        check("R4 low level holds", q_a, 4'd1);

        // R7/R8/R9: clear in the middle of a count
        clear_a();
        mode_a = 2'b00;
        mode_b = 2'b00;
        for (int p = 0; p < 6; p++) pulse(0, 0);
        for (int p = 0; p < 3; p++) pulse(1, 0);
        check("R5 before clear", q_a, 4'd6);
        #3 clr_a = 1'b1;
        #2;
        check("R7 async clear", q_a, 4'd0);
        check("R8 other unit kept", q_b, 4'd3);
        pulse(0, 0);
        pulse(0, 1);
        check("R9 held during clear", q_a, 4'd0);
        clr_a = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 zero after release", q_a, 4'd0);
        check("R8 other unit still kept", q_b, 4'd3);
        pulse(0, 0);
        check("R9 first fall after release", q_a, 4'd1);

        // R10: cascade for divide by 100
        clear_a();
        clr_b = 1'b1;
        repeat (2) @(negedge clk);
        clr_b = 1'b0;
        casc = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 37; p++) pulse(0, 0);
        check("R10 cascade units", q_a, 4'd7);
        check("R10 cascade tens", q_b, 4'd3);
        for (int p = 37; p < 99; p++) pulse(0, 0);
        check("R10 at 99 units", q_a, 4'd9);
        check("R10 at 99 tens", q_b, 4'd9);
        pulse(0, 0);
        check("R10 wrap units", q_a, 4'd0);
        check("R10 wrap tens", q_b, 4'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule